// File: doc/BRIEF.md
# Capability Relocation Unit

This block is a two-cycle execution unit that a dynamic loader uses to produce relocated capabilities. Capabilities enter and leave in uncompressed form: a tag, a sealed flag, a base, a top one bit wider than an address, an address and a permission mask. The unit has two modes. Slide mode moves an untagged metadata bundle up by an integer. Authority mode builds a new capability from a tagged authority and an untagged bundle. The bundle gives a base relative to the authority's address, a length, an offset and permissions.

Operands are accepted with a valid/ready handshake. In the cycle after acceptance, the unit forms the new base, top and address. In the next cycle it checks containment and exactness, then presents a one-cycle done pulse with a 3-bit cause code and the result fields. Cause 0 means success, 1 a tag violation, 2 a seal violation, 3 a length violation and 4 inexact bounds. Bounds are exact when base and top are both multiples of 2^E. E is the smallest exponent for which the length shifted right by E is below 2^MANT_W.

Top module: `cap_reloc_unit`

## Requirements
- R1: After reset, `out_done` is 0, `in_ready` is 1 and all result fields and `out_cause` are 0.
- R2: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in the following cycle. `out_done` is high for exactly one cycle, starting two clock edges after acceptance.
- R3: Slide mode (`in_mode`=0) adds `slide_amt` to the bundle base and address modulo 2^XLEN, and to the bundle top modulo 2^(XLEN+1). It keeps the bundle permissions and always returns a clear tag.
- R4: In slide mode, a bundle with its tag set gives cause 1.
- R5: In authority mode (`in_mode`=1), the new base is authority address plus bundle base, modulo 2^XLEN. The top is the new base plus (bundle top minus bundle base). The address is the new base plus (bundle address minus bundle base).
- R6: On success in authority mode, the result permissions are the bitwise AND of the authority and bundle permissions, and the result tag equals the authority tag.
- R7: In authority mode, an authority that is both tagged and sealed gives cause 2, whatever else is wrong.
- R8: In authority mode, if the new base is below the authority base or the new top is above the authority top, the cause is 3. This outranks inexact bounds, and a top equal to the authority top is accepted.
- R9: In either mode, result bounds whose base or top is not a multiple of 2^E give cause 4.
- R10: When the cause is nonzero, the result tag, base, top, address and permissions are all 0.
- R11: The sealed flag of an untagged authority has no effect: the operation succeeds with a clear result tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid |
| in_ready | output | 1 | Unit can accept operands |
| in_mode | input | 1 | 0 = slide, 1 = authority |
| auth_tag | input | 1 | Authority tag |
| auth_sealed | input | 1 | Authority sealed flag |
| auth_base | input | XLEN | Authority base |
| auth_top | input | XLEN+1 | Authority top |
| auth_addr | input | XLEN | Authority address |
| auth_perms | input | PERM_W | Authority permissions |
| bun_tag | input | 1 | Bundle tag |
| bun_base | input | XLEN | Bundle base |
| bun_top | input | XLEN+1 | Bundle top |
| bun_addr | input | XLEN | Bundle address |
| bun_perms | input | PERM_W | Bundle permissions |
| slide_amt | input | XLEN | Slide distance (slide mode) |
| out_done | output | 1 | Result valid pulse |
| out_cause | output | 3 | Exception cause, 0 = success |
| res_tag | output | 1 | Result tag |
| res_base | output | XLEN | Result base |
| res_top | output | XLEN+1 | Result top |
| res_addr | output | XLEN | Result address |
| res_perms | output | PERM_W | Result permissions |

## Verification
Slide mode is tested with a small aligned bundle and with a bundle that wraps past the top of the address space. Together these separate correct modular addition from an adder of the wrong width. Authority mode is tested with a span strictly inside the authority, with a span ending exactly at the authority top, with a span starting below the authority base, and with an untagged sealed authority. These separate the two containment comparisons and their boundary, and show that the sealed flag matters only when the authority is tagged. Operand sets that violate several rules at once (sealed and out of span, out of span and misaligned) establish cause priority. Back-to-back issues confirm the stall and the latency.

// File: rtl/cap_reloc_pkg.sv
package cap_reloc_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_TAG     = 3'd1,
    CAUSE_SEAL    = 3'd2,
    CAUSE_LENGTH  = 3'd3,
    CAUSE_INEXACT = 3'd4
  } cause_e;

  typedef enum logic {
    MODE_SLIDE = 1'b0,
    MODE_AUTH  = 1'b1
  } mode_e;
endpackage

// File: rtl/cap_reloc_exact.sv
module cap_reloc_exact #(
  parameter int XLEN   = 32,
  parameter int MANT_W = 8
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN:0]   top,
  input  logic [XLEN:0]   len,
  output logic            exact
);
  localparam int EW = $clog2(XLEN + 2) + 1;
  localparam logic [XLEN:0] LIM = {{XLEN{1'b0}}, 1'b1} << MANT_W;

  logic [EW-1:0] exp_sel;
  logic [XLEN:0] low_mask;

  // smallest exponent that brings the length under the mantissa limit
  always_comb begin
    exp_sel = '0;
    for (int e = 0; e <= XLEN; e++) begin
      if ((len >> e) >= LIM) exp_sel = EW'(e + 1);
    end
  end

  assign low_mask = ~({(XLEN+1){1'b1}} << exp_sel);
  assign exact    = ((({1'b0, base} | top) & low_mask) == '0);
endmodule

// File: rtl/cap_reloc_gen.sv
module cap_reloc_gen
  import cap_reloc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int PERM_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              mode,
  input  logic              a_tag,
  input  logic              a_sealed,
  input  logic [XLEN-1:0]   a_base,
  input  logic [XLEN:0]     a_top,
  input  logic [XLEN-1:0]   a_addr,
  input  logic [PERM_W-1:0] a_perms,
  input  logic              b_tag,
  input  logic [XLEN-1:0]   b_base,
  input  logic [XLEN:0]     b_top,
  input  logic [XLEN-1:0]   b_addr,
  input  logic [PERM_W-1:0] b_perms,
  input  logic [XLEN-1:0]   k,
  output logic              s1_valid,
  output logic              s1_mode,
  output cause_e            s1_cause,
  output logic              s1_tag,
  output logic [XLEN-1:0]   s1_base,
  output logic [XLEN+1:0]   s1_top,
  output logic [XLEN-1:0]   s1_addr,
  output logic [PERM_W-1:0] s1_perms,
  output logic [XLEN:0]     s1_len,
  output logic [XLEN-1:0]   s1_abase,
  output logic [XLEN:0]     s1_atop
);
  logic [XLEN:0]     len;
  logic [XLEN-1:0]   ofs, nb, na;
  logic [XLEN:0]     slide_top;
  logic [XLEN+1:0]   nt;
  logic [PERM_W-1:0] np;
  cause_e            nc;
  logic              ntag;

  assign len       = b_top - {1'b0, b_base};
  assign ofs       = b_addr - b_base;
  assign slide_top = b_top + {1'b0, k};

  always_comb begin
    if (mode == MODE_AUTH) begin
      nb   = a_addr + b_base;
      nt   = {2'b00, nb} + {1'b0, len};
      na   = nb + ofs;
      np   = a_perms & b_perms;
      nc   = (a_tag && a_sealed) ? CAUSE_SEAL : CAUSE_NONE;
      ntag = a_tag;
    end else begin
      nb   = b_base + k;
      nt   = {1'b0, slide_top};
      na   = b_addr + k;
      np   = b_perms;
      nc   = b_tag ? CAUSE_TAG : CAUSE_NONE;
      ntag = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_mode  <= 1'b0;
      s1_cause <= CAUSE_NONE;
      s1_tag   <= 1'b0;
      s1_base  <= '0;
      s1_top   <= '0;
      s1_addr  <= '0;
      s1_perms <= '0;
      s1_len   <= '0;
      s1_abase <= '0;
      s1_atop  <= '0;
    end else begin
      s1_valid <= load;
      if (load) begin
        s1_mode  <= mode;
        s1_cause <= nc;
        s1_tag   <= ntag;
        s1_base  <= nb;
        s1_top   <= nt;
        s1_addr  <= na;
        s1_perms <= np;
        s1_len   <= len;
        s1_abase <= a_base;
        s1_atop  <= a_top;
      end
    end
  end

  assert_seal_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (load && mode == MODE_AUTH && a_tag && a_sealed) |=> (s1_cause == CAUSE_SEAL));
  assert_slide_tagviol_R4: assert property (@(posedge clk) disable iff (rst)
    (load && mode == MODE_SLIDE && b_tag) |=> (s1_cause == CAUSE_TAG));
endmodule

// File: rtl/cap_reloc_check.sv
module cap_reloc_check
  import cap_reloc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int PERM_W = 8,
  parameter int MANT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic              s1_mode,
  input  cause_e            s1_cause,
  input  logic              s1_tag,
  input  logic [XLEN-1:0]   s1_base,
  input  logic [XLEN+1:0]   s1_top,
  input  logic [XLEN-1:0]   s1_addr,
  input  logic [PERM_W-1:0] s1_perms,
  input  logic [XLEN:0]     s1_len,
  input  logic [XLEN-1:0]   s1_abase,
  input  logic [XLEN:0]     s1_atop,
  output logic              out_done,
  output logic [CAUSE_W-1:0] out_cause,
  output logic              res_tag,
  output logic [XLEN-1:0]   res_base,
  output logic [XLEN:0]     res_top,
  output logic [XLEN-1:0]   res_addr,
  output logic [PERM_W-1:0] res_perms
);
  logic   in_span, exact;
  cause_e cause_n;

  assign in_span = ({2'b00, s1_base} >= {2'b00, s1_abase}) &&
                   (s1_top <= {1'b0, s1_atop});

  cap_reloc_exact #(.XLEN(XLEN), .MANT_W(MANT_W)) u_exact (
    .base  (s1_base),
    .top   (s1_top[XLEN:0]),
    .len   (s1_len),
    .exact (exact)
  );

  // priority: earlier-stage fault, then containment, then exactness
  always_comb begin
    if (s1_cause != CAUSE_NONE)                cause_n = s1_cause;
    else if (s1_mode == MODE_AUTH && !in_span) cause_n = CAUSE_LENGTH;
    else if (!exact)                           cause_n = CAUSE_INEXACT;
    else                                       cause_n = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done  <= 1'b0;
      out_cause <= '0;
      res_tag   <= 1'b0;
      res_base  <= '0;
      res_top   <= '0;
      res_addr  <= '0;
      res_perms <= '0;
    end else begin
      out_done <= s1_valid;
      if (s1_valid) begin
        out_cause <= cause_n;
        if (cause_n == CAUSE_NONE) begin
          res_tag   <= s1_tag;
          res_base  <= s1_base;
          res_top   <= s1_top[XLEN:0];
          res_addr  <= s1_addr;
          res_perms <= s1_perms;
        end else begin
          res_tag   <= 1'b0;
          res_base  <= '0;
          res_top   <= '0;
          res_addr  <= '0;
          res_perms <= '0;
        end
      end
    end
  end

  assert_fail_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_cause != '0) |-> (!res_tag && res_base == '0 && res_top == '0 &&
                                       res_addr == '0 && res_perms == '0));
  assert_slide_untagged_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode == MODE_SLIDE) |=> !res_tag);
  assert_cause_legal_R9: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (out_cause <= 3'd4));
endmodule

// File: rtl/cap_reloc_unit.sv
module cap_reloc_unit
  import cap_reloc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int PERM_W = 8,
  parameter int MANT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_mode,
  input  logic              auth_tag,
  input  logic              auth_sealed,
  input  logic [XLEN-1:0]   auth_base,
  input  logic [XLEN:0]     auth_top,
  input  logic [XLEN-1:0]   auth_addr,
  input  logic [PERM_W-1:0] auth_perms,
  input  logic              bun_tag,
  input  logic [XLEN-1:0]   bun_base,
  input  logic [XLEN:0]     bun_top,
  input  logic [XLEN-1:0]   bun_addr,
  input  logic [PERM_W-1:0] bun_perms,
  input  logic [XLEN-1:0]   slide_amt,
  output logic              out_done,
  output logic [CAUSE_W-1:0] out_cause,
  output logic              res_tag,
  output logic [XLEN-1:0]   res_base,
  output logic [XLEN:0]     res_top,
  output logic [XLEN-1:0]   res_addr,
  output logic [PERM_W-1:0] res_perms
);
  logic              fire;
  logic              s1_valid, s1_mode, s1_tag;
  cause_e            s1_cause;
  logic [XLEN-1:0]   s1_base, s1_addr, s1_abase;
  logic [XLEN+1:0]   s1_top;
  logic [PERM_W-1:0] s1_perms;
  logic [XLEN:0]     s1_len, s1_atop;

  assign in_ready = ~s1_valid;
  assign fire     = in_valid & in_ready;

  cap_reloc_gen #(.XLEN(XLEN), .PERM_W(PERM_W)) u_gen (
    .clk(clk), .rst(rst), .load(fire), .mode(in_mode),
    .a_tag(auth_tag), .a_sealed(auth_sealed), .a_base(auth_base),
    .a_top(auth_top), .a_addr(auth_addr), .a_perms(auth_perms),
    .b_tag(bun_tag), .b_base(bun_base), .b_top(bun_top),
    .b_addr(bun_addr), .b_perms(bun_perms), .k(slide_amt),
    .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_cause(s1_cause),
    .s1_tag(s1_tag), .s1_base(s1_base), .s1_top(s1_top),
    .s1_addr(s1_addr), .s1_perms(s1_perms), .s1_len(s1_len),
    .s1_abase(s1_abase), .s1_atop(s1_atop)
  );

  cap_reloc_check #(.XLEN(XLEN), .PERM_W(PERM_W), .MANT_W(MANT_W)) u_chk (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_mode(s1_mode),
    .s1_cause(s1_cause), .s1_tag(s1_tag), .s1_base(s1_base),
    .s1_top(s1_top), .s1_addr(s1_addr), .s1_perms(s1_perms),
    .s1_len(s1_len), .s1_abase(s1_abase), .s1_atop(s1_atop),
    .out_done(out_done), .out_cause(out_cause), .res_tag(res_tag),
    .res_base(res_base), .res_top(res_top), .res_addr(res_addr),
    .res_perms(res_perms)
  );

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    fire |-> ##2 out_done);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);
  assert_tag_success_R6: assert property (@(posedge clk) disable iff (rst)
    (out_done && res_tag) |-> (out_cause == '0));
endmodule

// File: tb/sim_cap_reloc_unit.sv
module sim_cap_reloc_unit;
  localparam int XLEN = 32, PERM_W = 8, MANT_W = 8;

  typedef struct packed {
    logic [2:0]        cause;
    logic              tag;
    logic [XLEN-1:0]   base;
    logic [XLEN:0]     top;
    logic [XLEN-1:0]   addr;
    logic [PERM_W-1:0] perms;
  } res_t;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready, in_mode = 1'b0;
  logic auth_tag = 1'b0, auth_sealed = 1'b0, bun_tag = 1'b0;
  logic [XLEN-1:0] auth_base = '0, auth_addr = '0, bun_base = '0, bun_addr = '0, slide_amt = '0;
  logic [XLEN:0] auth_top = '0, bun_top = '0;
  logic [PERM_W-1:0] auth_perms = '0, bun_perms = '0;
  logic out_done, res_tag;
  logic [2:0] out_cause;
  logic [XLEN-1:0] res_base, res_addr;
  logic [XLEN:0] res_top;
  logic [PERM_W-1:0] res_perms;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  res_t exp_q[$];
  string req_q[$];
  int acc_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cap_reloc_unit #(.XLEN(XLEN), .PERM_W(PERM_W), .MANT_W(MANT_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode),
    .auth_tag(auth_tag), .auth_sealed(auth_sealed), .auth_base(auth_base),
    .auth_top(auth_top), .auth_addr(auth_addr), .auth_perms(auth_perms),
    .bun_tag(bun_tag), .bun_base(bun_base), .bun_top(bun_top), .bun_addr(bun_addr),
    .bun_perms(bun_perms), .slide_amt(slide_amt), .out_done(out_done),
    .out_cause(out_cause), .res_tag(res_tag), .res_base(res_base),
    .res_top(res_top), .res_addr(res_addr), .res_perms(res_perms));

  task automatic check(input string req, input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic bit is_exact(input logic [63:0] b, input logic [63:0] t, input logic [63:0] l);
    int e = 0;
    logic [63:0] m;
    while ((l >> e) >= (64'd1 << MANT_W)) e++;
    m = (64'd1 << e) - 64'd1;
    return ((b | t) & m) == 64'd0;
  endfunction

  // reference model written from the requirements
  function automatic res_t model(input bit md, input bit at, input bit asl,
      input logic [63:0] ab, input logic [63:0] atp, input logic [63:0] aa, input logic [7:0] ap,
      input bit bt, input logic [63:0] bb, input logic [63:0] btp, input logic [63:0] ba,
      input logic [7:0] bp, input logic [63:0] kk);
    res_t r;
    logic [63:0] m32 = 64'hFFFF_FFFF, m33 = 64'h1_FFFF_FFFF;
    logic [63:0] nb, nt, na, ln;
    r = '0;
    ln = (btp - bb) & m33;
    if (!md) begin
      nb = (bb + kk) & m32; nt = (btp + kk) & m33; na = (ba + kk) & m32;
      if (bt) r.cause = 3'd1;
      else if (!is_exact(nb, nt, ln)) r.cause = 3'd4;
      else begin r.base = nb[31:0]; r.top = nt[32:0]; r.addr = na[31:0]; r.perms = bp; end
    end else begin
      nb = (aa + bb) & m32; nt = nb + ln; na = (nb + ((ba - bb) & m32)) & m32;
      if (at && asl) r.cause = 3'd2;
      else if (nb < ab || nt > atp) r.cause = 3'd3;
      else if (!is_exact(nb, nt, ln)) r.cause = 3'd4;
      else begin
        r.tag = at; r.base = nb[31:0]; r.top = nt[32:0]; r.addr = na[31:0]; r.perms = ap & bp;
      end
    end
    return r;
  endfunction

  task automatic issue(input string req, input bit md, input bit at, input bit asl,
      input logic [63:0] ab, input logic [63:0] atp, input logic [63:0] aa, input logic [7:0] ap,
      input bit bt, input logic [63:0] bb, input logic [63:0] btp, input logic [63:0] ba,
      input logic [7:0] bp, input logic [63:0] kk);
    in_mode = md; auth_tag = at; auth_sealed = asl; auth_base = ab[31:0]; auth_top = atp[32:0];
    auth_addr = aa[31:0]; auth_perms = ap; bun_tag = bt; bun_base = bb[31:0];
    bun_top = btp[32:0]; bun_addr = ba[31:0]; bun_perms = bp; slide_amt = kk[31:0];
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    exp_q.push_back(model(md, at, asl, ab, atp, aa, ap, bt, bb, btp, ba, bp, kk));
    req_q.push_back(req);
    acc_q.push_back(cyc);
    in_valid = 1'b0;
    check("R2", in_ready == 1'b0, $sformatf("in_ready after accept act=%0b exp=0", in_ready));
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_done) begin
      if (exp_q.size() == 0) check("R2", 1'b0, "unexpected out_done act=1 exp=0");
      else begin
        res_t e, a;
        string rq;
        int ac;
        e = exp_q.pop_front(); rq = req_q.pop_front(); ac = acc_q.pop_front();
        a = {out_cause, res_tag, res_base, res_top, res_addr, res_perms};
        check(rq, a == e, $sformatf("act cause=%0d tag=%0b b=%h t=%h a=%h p=%h exp cause=%0d tag=%0b b=%h t=%h a=%h p=%h",
              a.cause, a.tag, a.base, a.top, a.addr, a.perms,
              e.cause, e.tag, e.base, e.top, e.addr, e.perms));
        check("R2", cyc == ac + 1, $sformatf("latency act=%0d exp=%0d", cyc - ac + 1, 2));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", out_done == 0 && in_ready == 1 && out_cause == 0 && res_base == 0 &&
          res_top == 0 && res_addr == 0 && res_perms == 0 && res_tag == 0,
          $sformatf("reset act done=%0b rdy=%0b base=%h exp done=0 rdy=1 base=0", out_done, in_ready, res_base));
    // R3 slide, aligned
    issue("R3", 0, 0, 0, 0, 0, 0, 0, 0, 64'h100, 64'h180, 64'h120, 8'h5A, 64'h1000);
    // R3 slide with wrap past the address space
    issue("R3", 0, 0, 0, 0, 0, 0, 0, 0, 64'hFFFF_FF00, 64'h1_0000_0000, 64'hFFFF_FF10, 8'hC3, 64'h200);
    // R4 tagged bundle in slide mode, R10 zeroed fields
    issue("R4", 0, 0, 0, 0, 0, 0, 0, 1, 64'h100, 64'h180, 64'h120, 8'h5A, 64'h1000);
    // R9 slide inexact: length 0x300 needs E=2, base 0x101 misaligned
    issue("R9", 0, 0, 0, 0, 0, 0, 0, 0, 64'h101, 64'h401, 64'h101, 8'h11, 64'h0);
    // R5 R6 authority success
    issue("R5", 1, 1, 0, 64'h10000, 64'h20000, 64'h10000, 8'hF3, 0, 64'h40, 64'h80, 64'h48, 8'h3C, 0);
    // R7 sealed authority, also out of span
    issue("R7", 1, 1, 1, 64'h10000, 64'h20000, 64'h10000, 8'hF3, 0, 64'hFF00, 64'h10100, 64'hFF00, 8'h3C, 0);
    // R8 above top, also misaligned: length outranks inexact
    issue("R8", 1, 1, 0, 64'h10000, 64'h20000, 64'h10000, 8'hFF, 0, 64'hFF01, 64'h10301, 64'hFF01, 8'hFF, 0);
    // R8 below authority base
    issue("R8", 1, 1, 0, 64'h10000, 64'h20000, 64'h0F000, 8'hFF, 0, 64'h40, 64'h80, 64'h40, 8'hFF, 0);
    // R8 boundary: top equal to authority top is accepted
    issue("R8", 1, 1, 0, 64'h10000, 64'h20000, 64'h10000, 8'h0F, 0, 64'hFF00, 64'h10000, 64'hFF10, 8'hFF, 0);
    // R9 authority inexact
    issue("R9", 1, 1, 0, 64'h10000, 64'h20000, 64'h10000, 8'hFF, 0, 64'h41, 64'h341, 64'h41, 8'hFF, 0);
    // R11 untagged sealed authority: success, clear tag; R6 perms AND
    issue("R11", 1, 0, 1, 64'h10000, 64'h20000, 64'h10000, 8'hF3, 0, 64'h40, 64'h80, 64'h48, 8'h3C, 0);
    // R10 slide tag violation with nonzero inputs again
    issue("R10", 0, 0, 0, 0, 0, 0, 0, 1, 64'h200, 64'h300, 64'h200, 8'hFF, 64'h40);
    repeat (4) @(negedge clk);
    check("R2", exp_q.size() == 0, $sformatf("pending results act=%0d exp=0", exp_q.size()));
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2: watchdog expired act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule